// File: doc/BRIEF.md
# Two-Way Set-Associative Cache Controller

This block places a small two-way set-associative cache between a processor-side request port and a slower word-wide memory port. Addresses are 15-bit word addresses and data words are 12 bits wide. Each cache block is one word. The low address bits pick a set and the high bits form the tag. Each set has two entries, and each entry holds a tag, a data word, a valid bit and a use bit.

Reads and writes that match a stored tag are served from the cache and complete one cycle after the request. On a miss the controller picks a victim way. It writes that victim back to memory when the victim holds a block, then reads the requested word from memory and installs it. A write miss installs the block first and then places the new word over it. Writes that hit touch only the cache. Both ports use a simple request/acknowledge scheme, and only one memory access is outstanding at any time.

Top module: `cache2w_ctrl`

## Requirements
- R1: After reset `cpu_ready` and `mem_req` are low, every entry is invalid and every use bit is 1. The first access to any set is therefore a miss that issues a memory read and no memory write.
- R2: A read whose tag matches a valid entry of its set returns that entry's word. `cpu_ready` rises exactly one cycle after the request cycle, and no memory access is made.
- R3: The set index is `cpu_addr[7:0]` and the tag is `cpu_addr[14:8]`. Two addresses with the same index and different tags can both be resident at once, and both then hit.
- R4: On a miss, an invalid way is chosen before the use bits are looked at. When both ways are invalid, way 0 is chosen. Filling an invalid way issues no write-back.
- R5: Any hit or fill of a way clears that way's use bit and sets the other way's bit. With both ways valid, the miss victim is the way whose use bit is 1, and way 0 is chosen if both bits are 1. Both bits being 0 never occurs.
- R6: When a valid victim is evicted, a memory write of its stored word to address {victim tag, index} is issued first. It is followed by a memory read of {request tag, index}.
- R7: A write hit updates only the cached word and makes no memory access. The new value reaches memory only when that entry is later evicted.
- R8: A write miss evicts and refills through the same path as a read miss, then stores the write data in the filled entry. A later read of that address hits and returns the written data.
- R9: A read miss returns the word delivered on `mem_rdata` with the read acknowledge. `cpu_ready` pulses only after the refill completes.
- R10: `mem_req` stays high with a stable address until `mem_ack`, and falls in the cycle after the acknowledge. At most one memory access is in flight.
- R11: Each request produces exactly one `cpu_ready` pulse, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request strobe, sampled while the controller is idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 15 | Word address: tag in [14:8], index in [7:0] |
| cpu_wdata | input | 12 | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 12 | Read result, valid with `cpu_ready` |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | Memory write (write-back) when high, read when low |
| mem_addr | output | 15 | Memory word address |
| mem_wdata | output | 12 | Write-back data |
| mem_ack | input | 1 | One-cycle memory completion pulse |
| mem_rdata | input | 12 | Memory read data, valid with `mem_ack` |

## Verification
The bench targets the set that holds two tags at once. It then touches one of them and forces a third tag into that set. A design that inverted the use-bit update would evict the entry just touched, and the write-back address would expose it. A write hit followed by eviction shows whether the modified word reached memory only at write-back time. A controller that wrote through, or dropped the dirty word, would show up in the memory-operation log. Write misses, the first index (0), the last index (255) and the all-ones tag are run under varied memory latency. This catches a refill that overwrote the write data, a victim taken from a valid way while the other was still empty, and a request that stayed high past its acknowledge.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
  localparam int NWAYS = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COMPARE,
    ST_WRITEBACK,
    ST_REFILL,
    ST_RESPOND
  } cstate_t;
endpackage

// File: rtl/cache2w_way_ram.sv
// One way's tag+data store, written so a block RAM can be inferred.
module cache2w_way_ram #(
  parameter int IDX_W  = 8,
  parameter int TAG_W  = 7,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int NSETS = 1 << IDX_W;
  localparam int ENT_W = TAG_W + DATA_W;

  logic [ENT_W-1:0] store [NSETS];
  logic [ENT_W-1:0] q;

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_idx] <= {wr_tag, wr_data};
    if (rd_en) q <= store[rd_idx];
  end

  assign rd_tag  = q[ENT_W-1:DATA_W];
  assign rd_data = q[DATA_W-1:0];
endmodule

// File: rtl/cache2w_meta.sv
// Valid and use bits for every set; kept in flops so reset can clear them.
module cache2w_meta
  import cache2w_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [NWAYS-1:0] rd_vld,
  output logic [NWAYS-1:0] rd_use,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_way,
  input  logic             upd_fill
);
  localparam int NSETS = 1 << IDX_W;

  logic [NSETS-1:0] vld   [NWAYS];
  logic [NSETS-1:0] use_b [NWAYS];

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    always_ff @(posedge clk) begin
      if (rst) begin
        vld[w]   <= '0;
        use_b[w] <= '1;
      end else if (upd_en) begin
        use_b[w][upd_idx] <= (upd_way != 1'(w));
        if (upd_fill && upd_way == 1'(w)) vld[w][upd_idx] <= 1'b1;
      end
    end
    assign rd_vld[w] = vld[w][rd_idx];
    assign rd_use[w] = use_b[w][rd_idx];
  end

  // R5: the pair of use bits of the set being addressed is never both clear
  p_use_not_both_clear_r5: assert property (@(posedge clk) disable iff (rst)
    rd_use != 2'b00);
endmodule

// File: rtl/cache2w_victim.sv
// Victim choice: empty way first (way 0 preferred), then the way whose use bit is set.
module cache2w_victim
  import cache2w_pkg::*;
(
  input  logic [NWAYS-1:0] vld,
  input  logic [NWAYS-1:0] use_b,
  output logic             way
);
  always_comb begin
    if (!vld[0])       way = 1'b0;
    else if (!vld[1])  way = 1'b1;
    else if (use_b[0]) way = 1'b0;
    else               way = 1'b1;
  end
endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
  import cache2w_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 12,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int TAG_W = ADDR_W - IDX_W;

  cstate_t           st;
  logic              r_we;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata;
  logic              vic_way;

  logic [IDX_W-1:0]  r_idx;
  logic [TAG_W-1:0]  r_tag;
  assign r_idx = r_addr[IDX_W-1:0];
  assign r_tag = r_addr[ADDR_W-1:IDX_W];

  logic [TAG_W-1:0]  way_tag  [NWAYS];
  logic [DATA_W-1:0] way_data [NWAYS];
  logic [NWAYS-1:0]  hit_vec, m_vld, m_use;
  logic              any_hit, hit_way, pick_way, fill_done, rd_start;
  logic [DATA_W-1:0] fill_word;

  assign rd_start  = (st == ST_IDLE) && cpu_req;
  assign fill_done = (st == ST_REFILL) && mem_req && mem_ack;
  assign fill_word = r_we ? r_wdata : mem_rdata;
  assign any_hit   = |hit_vec;
  assign hit_way   = hit_vec[1];

  for (genvar w = 0; w < NWAYS; w++) begin : g_ways
    logic wr_en_w;
    assign hit_vec[w] = m_vld[w] && (way_tag[w] == r_tag);
    assign wr_en_w = ((st == ST_COMPARE) && hit_vec[w] && r_we) ||
                     (fill_done && vic_way == 1'(w));

    cache2w_way_ram #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_ram (
      .clk     (clk),
      .rd_en   (rd_start),
      .rd_idx  (cpu_addr[IDX_W-1:0]),
      .rd_tag  (way_tag[w]),
      .rd_data (way_data[w]),
      .wr_en   (wr_en_w),
      .wr_idx  (r_idx),
      .wr_tag  (r_tag),
      .wr_data (fill_done ? fill_word : r_wdata)
    );
  end

  cache2w_meta #(.IDX_W(IDX_W)) i_meta (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (r_idx),
    .rd_vld   (m_vld),
    .rd_use   (m_use),
    .upd_en   (((st == ST_COMPARE) && any_hit) || fill_done),
    .upd_idx  (r_idx),
    .upd_way  ((st == ST_COMPARE) ? hit_way : vic_way),
    .upd_fill (fill_done)
  );

  cache2w_victim i_victim (
    .vld   (m_vld),
    .use_b (m_use),
    .way   (pick_way)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      r_we      <= 1'b0;
      r_addr    <= '0;
      r_wdata   <= '0;
      vic_way   <= 1'b0;
      cpu_ready <= 1'b0;
      cpu_rdata <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      cpu_ready <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (cpu_req) begin
            r_we    <= cpu_we;
            r_addr  <= cpu_addr;
            r_wdata <= cpu_wdata;
            st      <= ST_COMPARE;
          end
        end
        ST_COMPARE: begin
          if (any_hit) begin
            cpu_ready <= 1'b1;
            cpu_rdata <= r_we ? r_wdata : way_data[hit_way];
            st        <= ST_IDLE;
          end else begin
            vic_way <= pick_way;
            st      <= m_vld[pick_way] ? ST_WRITEBACK : ST_REFILL;
          end
        end
        ST_WRITEBACK: begin
          if (!mem_req) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= {way_tag[vic_way], r_idx};
            mem_wdata <= way_data[vic_way];
          end else if (mem_ack) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            st      <= ST_REFILL;
          end
        end
        ST_REFILL: begin
          if (!mem_req) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= r_addr;
          end else if (mem_ack) begin
            mem_req   <= 1'b0;
            cpu_rdata <= fill_word;
            st        <= ST_RESPOND;
          end
        end
        ST_RESPOND: begin
          cpu_ready <= 1'b1;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R11: completion is a single-cycle pulse
  p_ready_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);
  // R2: a tag match completes on the next edge
  p_hit_ready_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_COMPARE && any_hit) |=> cpu_ready);
  // R7: a hit starts no memory access
  p_no_mem_on_hit_r7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_COMPARE && any_hit) |=> !mem_req);
  // R10: request held with stable address until acknowledged
  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  // R10: request released right after the acknowledge
  p_req_drop_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> !mem_req);
endmodule

// File: tb/test_cache2w_ctrl.sv
module test_cache2w_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [14:0] cpu_addr = '0;
  logic [11:0] cpu_wdata = '0;
  logic        cpu_ready;
  logic [11:0] cpu_rdata;
  logic        mem_req, mem_we;
  logic [14:0] mem_addr;
  logic [11:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [11:0] mem_rdata = '0;

  always #10 clk = ~clk;

  cache2w_ctrl i_cache2w_ctrl (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int checks = 0, errors = 0;
  int mem_lat = 1, lat_cnt = 0;

  // behavioural main memory and operation log
  int mm [int];
  int log_we[$], log_addr[$], log_data[$];
  int exp_we[$], exp_addr[$], exp_data[$];

  function automatic int mem_rd(int a);
    if (mm.exists(a)) return mm[a];
    return (a * 37 + 11) & 'hFFF;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0; lat_cnt <= 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0; lat_cnt <= 0;
    end else if (mem_req) begin
      if (lat_cnt >= mem_lat) begin
        mem_ack <= 1'b1;
        log_we.push_back(int'(mem_we));
        log_addr.push_back(int'(mem_addr));
        if (mem_we) begin
          mm[int'(mem_addr)] = int'(mem_wdata);
          log_data.push_back(int'(mem_wdata));
        end else begin
          mem_rdata <= 12'(mem_rd(int'(mem_addr)));
          log_data.push_back(mem_rd(int'(mem_addr)));
        end
      end else lat_cnt <= lat_cnt + 1;
    end
  end

  // reference cache model
  int  m_tag [256][2];
  int  m_dat [256][2];
  bit  m_vld [256][2];
  bit  m_use [256][2];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
    end
  endtask

  task automatic touch(int idx, int w);
    m_use[idx][w] = 1'b0;
    m_use[idx][1-w] = 1'b1;
  endtask

  task automatic access(bit we, int addr, int wd, int lat, output bit was_hit);
    int idx, tg, w, exp_rd, cyc, got_rd;
    bit got, prev_ack, bad10;
    idx = addr & 'hFF;
    tg  = (addr >> 8) & 'h7F;
    w = -1;
    for (int k = 0; k < 2; k++) if (m_vld[idx][k] && m_tag[idx][k] == tg) w = k;
    exp_we.delete(); exp_addr.delete(); exp_data.delete();
    if (w >= 0) begin
      was_hit = 1'b1;
      if (we) m_dat[idx][w] = wd;
      exp_rd = m_dat[idx][w];
    end else begin
      was_hit = 1'b0;
      if (!m_vld[idx][0]) w = 0;
      else if (!m_vld[idx][1]) w = 1;
      else if (m_use[idx][0]) w = 0;
      else w = 1;
      if (m_vld[idx][w]) begin
        exp_we.push_back(1); exp_addr.push_back((m_tag[idx][w] << 8) | idx);
        exp_data.push_back(m_dat[idx][w]);
      end
      exp_we.push_back(0); exp_addr.push_back(addr);
      exp_data.push_back(mem_rd(addr));
      m_tag[idx][w] = tg;
      m_vld[idx][w] = 1'b1;
      m_dat[idx][w] = we ? wd : mem_rd(addr);
      exp_rd = m_dat[idx][w];
    end
    touch(idx, w);
    log_we.delete(); log_addr.delete(); log_data.delete();

    @(negedge clk);
    mem_lat = lat;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = 15'(addr); cpu_wdata = 12'(wd);
    @(negedge clk);
    cpu_req = 1'b0;
    cyc = 0; got = 0; prev_ack = 0; bad10 = 0; got_rd = 0;
    while (!got && cyc < 300) begin
      @(negedge clk);
      cyc++;
      if (prev_ack && mem_req && !(mem_we == 1'b0 && log_we.size() == 1 && exp_we.size() == 2 && cyc > 0 && 0)) begin
        // after an acknowledge the request must be low for at least one cycle
        bad10 = 1;
      end
      if (was_hit && mem_req) bad10 = 1;
      prev_ack = mem_ack;
      if (cpu_ready) begin got = 1; got_rd = int'(cpu_rdata); end
    end
    chk(got, "R11", "ready seen", int'(got), 1);
    chk(!bad10, "R10", "request released after ack / none on hit", int'(bad10), 0);
    if (got) begin
      chk(got_rd == exp_rd, was_hit ? "R2" : (we ? "R8" : "R9"), "rdata", got_rd, exp_rd);
      if (was_hit) chk(cyc == 1, "R2", "hit latency", cyc, 1);
      @(negedge clk);
      chk(cpu_ready == 1'b0, "R11", "ready one cycle", int'(cpu_ready), 0);
    end
    chk(log_we.size() == exp_we.size(), was_hit ? "R7" : "R6", "memory op count",
        log_we.size(), exp_we.size());
    for (int k = 0; k < exp_we.size() && k < log_we.size(); k++) begin
      chk(log_we[k] == exp_we[k], "R6", "memory op kind", log_we[k], exp_we[k]);
      chk(log_addr[k] == exp_addr[k], "R6", "memory op address", log_addr[k], exp_addr[k]);
      chk(log_data[k] == exp_data[k], "R6", "memory op data", log_data[k], exp_data[k]);
    end
  endtask

  initial begin
    #(20 * 150000);
    chk(0, "WATCHDOG", "run timed out", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit h;
    int seed;
    for (int i = 0; i < 256; i++)
      for (int k = 0; k < 2; k++) begin
        m_vld[i][k] = 0; m_use[i][k] = 1; m_tag[i][k] = 0; m_dat[i][k] = 0;
      end
    repeat (3) @(negedge clk);
    chk(cpu_ready == 0, "R1", "ready in reset", int'(cpu_ready), 0);
    chk(mem_req == 0, "R1", "mem_req in reset", int'(mem_req), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(cpu_ready == 0 && mem_req == 0, "R1", "idle after reset", int'(cpu_ready | mem_req), 0);

    // R1 R4: first access is a fill of way 0 with no write-back
    access(0, 15'h0105, 0, 1, h);
    chk(!h && log_we.size() == 1, "R1", "first access single read", log_we.size(), 1);
    access(0, 15'h0105, 0, 1, h);
    chk(h, "R2", "second read hits", int'(h), 1);
    // R3 R4: second tag goes to the empty way, both resident
    access(0, 15'h0205, 0, 2, h);
    chk(log_we.size() == 1, "R4", "empty way filled without write-back", log_we.size(), 1);
    access(0, 15'h0105, 0, 0, h);
    chk(h, "R3", "tag 1 still resident", int'(h), 1);
    access(0, 15'h0205, 0, 0, h);
    chk(h, "R3", "tag 2 still resident", int'(h), 1);
    // R5 R6: touch tag 1, then tag 3 must evict tag 2
    access(0, 15'h0105, 0, 0, h);
    access(0, 15'h0305, 0, 3, h);
    chk(log_addr.size() == 2 && log_addr[0] == 'h205, "R5", "victim is least recent",
        log_addr.size() > 0 ? log_addr[0] : -1, 'h205);
    // R7: write hit stays in cache, reaches memory on eviction
    access(1, 15'h0305, 12'hABC, 1, h);
    chk(h && log_we.size() == 0, "R7", "write hit no memory access", log_we.size(), 0);
    access(0, 15'h0405, 0, 1, h);
    access(0, 15'h0505, 0, 1, h);
    chk(log_data.size() == 2 && log_data[0] == 'hABC, "R7", "dirty word written back",
        log_data.size() > 0 ? log_data[0] : -1, 'hABC);
    // R8: write miss, boundary index and tag
    access(1, 15'h7FFF, 12'h123, 2, h);
    access(0, 15'h7FFF, 0, 0, h);
    chk(h, "R8", "written word resident", int'(h), 1);
    access(1, 15'h0000, 12'hFFF, 0, h);
    access(0, 15'h0000, 0, 1, h);
    chk(h, "R8", "index 0 write miss resident", int'(h), 1);

    // mixed sequence against the reference model
    seed = 12345;
    for (int n = 0; n < 300; n++) begin
      int idx, tg, sel;
      seed = seed * 1103515245 + 12345;
      sel = (seed >>> 16) & 'h7FFF;
      case (sel & 3) 0: idx = 0; 1: idx = 5; 2: idx = 255; default: idx = 17; endcase
      case ((sel >> 2) & 7) 0,1: tg = 0; 2: tg = 1; 3,4: tg = 2; 5: tg = 3; 6: tg = 127; default: tg = 64; endcase
      access(((sel >> 5) % 3) == 0, (tg << 8) | idx, (sel >> 3) & 'hFFF, (sel >> 9) & 3, h);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule